// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block decides when an acquisition trigger fires by walking through a short program of conditions. Around it sit always-running event sources: edge detectors that raise a one-cycle flag per detected edge, and serial byte assemblers that raise a one-cycle byte-valid strobe together with the assembled byte. The sequencer never enables or disables those sources. It only chooses, step by step, which of their outputs it reacts to.

Each program step selects one event source and can require that a byte source deliver a given value. It names a successor step for a match and another for a mismatch, plus an abort source that returns the sequence to step 0. A step may be marked as final. When its condition matches, the block emits a one-cycle trigger pulse, returns to step 0 and disarms until the arm input is seen high again. A typical use is a serial pattern match: wait for a select line to fall, accept a first byte, fire on a second byte, and restart on any wrong byte or on the select line rising.

The program is loaded through a valid/ready write port. `wr_ready_o` is high exactly while the sequencer is idle. A beat transfers on a clock edge where valid and ready are both high. A write presented while ready is low is dropped, not held. The sender must keep valid asserted until ready returns if it wants the write to land. The event inputs have no back-pressure, because the sources cannot stall.

Top module: `trg_seq`

## Requirements
- R1: After reset, `trig_o` is 0, `armed_o` is 0, `step_o` is 0 and `wr_ready_o` is 1. Every step of the program is inert: its event select and abort select are both 7, which never fires.
- R2: A write transfers when `wr_valid_i` and `wr_ready_o` are both high, and `wr_ready_o` equals the inverse of `armed_o`. The 22-bit step word is laid out as follows: [21:19] event select, [18] compare enable, [17:10] compare byte, [9:7] abort select, [6] final-step flag, [5:3] next step on match, [2:0] next step on mismatch.
- R3: A write presented while the sequencer is armed leaves the program unchanged.
- R4: When idle, a high `arm_i` makes the block armed at step 0 after the next clock edge. Events present during that arming cycle are not acted on.
- R5: Event selects 0 to 3 pick `edge_i[0]` to `edge_i[3]`. Selects 4 and 5 pick the byte strobes of lanes 0 and 1, and the compare uses that same lane's byte. Select 6 is always true and select 7 never fires. The same encoding applies to the abort select.
- R6: While armed, when the selected event fires and the step matches without the final flag, `step_o` becomes the step's match successor after that edge.
- R7: With compare enabled on a byte select, an equal byte counts as a match and an unequal byte sends `step_o` to the mismatch successor. On an edge select, compare enable has no effect.
- R8: While armed, if the current step's abort source fires, `step_o` becomes 0 and no trigger is produced, even when the step's condition matches in the same cycle.
- R9: A match on a final step raises `trig_o` for exactly one cycle, together with `step_o` = 0 and `armed_o` = 0. The block then stays idle until `arm_i` is high.
- R10: While armed, a cycle with neither abort, match nor mismatch leaves `step_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm request, sampled while idle |
| edge_i | input | N_EDGE (4) | One-cycle edge flags from edge detectors |
| bvld_i | input | N_BYTE (2) | One-cycle byte-valid strobes, one per lane |
| bdat_i | input | N_BYTE*8 (16) | Byte per lane, lane k at bits [8k+7:8k] |
| wr_valid_i | input | 1 | Program write valid |
| wr_ready_o | output | 1 | Program write ready (high while idle) |
| wr_addr_i | input | 3 | Step index to write |
| wr_data_i | input | 22 | Step word |
| trig_o | output | 1 | One-cycle trigger pulse |
| armed_o | output | 1 | Sequencer is armed |
| step_o | output | 3 | Current step index |

## Verification
The hardest situation to reach is a cycle in which the abort source and a matching byte on the final step arrive together. That requires the program to have been walked to its last step first. Directed stimulus runs the serial-match program to step 2 and then presents the final byte and the abort edge in the same cycle. A second program covers the always-true source, byte lane 1 and compare enable on an edge select. A long randomized phase then mixes arming, sparse events and write attempts in both states, with a behavioural model compared on every clock.

// File: rtl/trg_seq_pkg.sv
package trg_seq_pkg;

  localparam int SEL_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 3;
  localparam int N_SRC   = 1 << SEL_W;

  localparam logic [SEL_W-1:0] SRC_ALWAYS = 3'd6;
  localparam logic [SEL_W-1:0] SRC_NEVER  = 3'd7;

  typedef struct packed {
    logic [SEL_W-1:0]  ev_sel;
    logic              cmp_en;
    logic [BYTE_W-1:0] cmp_val;
    logic [SEL_W-1:0]  abort_sel;
    logic              fire;
    logic [IDX_W-1:0]  nxt_hit;
    logic [IDX_W-1:0]  nxt_miss;
  } step_t;

  localparam int STEP_W = $bits(step_t);

  function automatic step_t inert_step();
    step_t s;
    s           = '0;
    s.ev_sel    = SRC_NEVER;
    s.abort_sel = SRC_NEVER;
    return s;
  endfunction

endpackage

// File: rtl/trg_prog_mem.sv
module trg_prog_mem
  import trg_seq_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  step_t            wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output step_t            rd_step_o
);

  step_t mem [STEPS];
  logic  wr_fire;

  assign wr_ready_o = !armed_i;
  assign wr_fire    = wr_valid_i && wr_ready_o;

  for (genvar g = 0; g < STEPS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= inert_step();
      end else if (wr_fire && (wr_addr_i == IDX_W'(g))) begin
        mem[g] <= wr_data_i;
      end
    end

    // R3: a write offered while armed must not disturb any slot
    p_drop_armed_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_i && wr_valid_i) |=> $stable(mem[g]));
  end

  always_comb begin
    if (32'(rd_idx_i) < STEPS) rd_step_o = mem[rd_idx_i];
    else                       rd_step_o = inert_step();
  end

endmodule

// File: rtl/trg_event_sel.sv
module trg_event_sel
  import trg_seq_pkg::*;
#(
  parameter int N_EDGE = 4,
  parameter int N_BYTE = 2
) (
  input  logic [N_EDGE-1:0]        edge_i,
  input  logic [N_BYTE-1:0]        bvld_i,
  input  logic [N_BYTE*BYTE_W-1:0] bdat_i,
  input  step_t                    step_i,
  output logic                     hit_o,
  output logic                     miss_o,
  output logic                     abort_o
);

  logic [N_SRC-1:0]  src;
  logic [BYTE_W-1:0] lane_byte;
  logic              is_byte;
  logic              cmp_on;
  logic              fired;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    if (s < N_EDGE) begin : g_edge
      assign src[s] = edge_i[s];
    end else if (s < N_EDGE + N_BYTE) begin : g_byte
      assign src[s] = bvld_i[s-N_EDGE];
    end else if (s == int'(SRC_ALWAYS)) begin : g_always
      assign src[s] = 1'b1;
    end else begin : g_never
      assign src[s] = 1'b0;
    end
  end

  always_comb begin
    lane_byte = '0;
    is_byte   = 1'b0;
    for (int k = 0; k < N_BYTE; k++) begin
      if (step_i.ev_sel == SEL_W'(N_EDGE + k)) begin
        lane_byte = bdat_i[k*BYTE_W +: BYTE_W];
        is_byte   = 1'b1;
      end
    end
  end

  assign cmp_on  = step_i.cmp_en && is_byte;
  assign fired   = src[step_i.ev_sel];
  assign hit_o   = fired && (!cmp_on || (lane_byte == step_i.cmp_val));
  assign miss_o  = fired && cmp_on && (lane_byte != step_i.cmp_val);
  assign abort_o = src[step_i.abort_sel];

endmodule

// File: rtl/trg_step_ctrl.sv
module trg_step_ctrl
  import trg_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic             abort_i,
  input  step_t            step_i,
  output logic             armed_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             trig_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      ptr_o   <= '0;
      trig_o  <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (!armed_o) begin
        if (arm_i) begin
          armed_o <= 1'b1;
          ptr_o   <= '0;
        end
      end else if (abort_i) begin
        ptr_o <= '0;
      end else if (hit_i) begin
        if (step_i.fire) begin
          trig_o  <= 1'b1;
          armed_o <= 1'b0;
          ptr_o   <= '0;
        end else begin
          ptr_o <= step_i.nxt_hit;
        end
      end else if (miss_i) begin
        ptr_o <= step_i.nxt_miss;
      end
    end
  end

  p_arm_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && arm_i) |=> (armed_o && ptr_o == '0));

  p_hit_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !abort_i && hit_i && !step_i.fire) |=> (ptr_o == $past(step_i.nxt_hit)));

  p_miss_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !abort_i && miss_i) |=> (ptr_o == $past(step_i.nxt_miss)));

  p_abort_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && abort_i) |=> (ptr_o == '0 && !trig_o));

  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  p_disarm_on_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (!armed_o && ptr_o == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !abort_i && !hit_i && !miss_i) |=> (armed_o && $stable(ptr_o)));

endmodule

// File: rtl/trg_seq.sv
module trg_seq
  import trg_seq_pkg::*;
#(
  parameter int STEPS  = 8,
  parameter int N_EDGE = 4,
  parameter int N_BYTE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm_i,
  input  logic [N_EDGE-1:0]        edge_i,
  input  logic [N_BYTE-1:0]        bvld_i,
  input  logic [N_BYTE*BYTE_W-1:0] bdat_i,
  input  logic                     wr_valid_i,
  output logic                     wr_ready_o,
  input  logic [IDX_W-1:0]         wr_addr_i,
  input  logic [STEP_W-1:0]        wr_data_i,
  output logic                     trig_o,
  output logic                     armed_o,
  output logic [IDX_W-1:0]         step_o
);

  step_t cur_step;
  logic  hit, miss, abort_ev;
  logic  armed;
  logic [IDX_W-1:0] ptr;

  initial begin
    if (N_EDGE + N_BYTE > int'(SRC_ALWAYS))
      $error("event sources exceed the select space");
    if (STEPS > (1 << IDX_W))
      $error("step count exceeds index width");
  end

  trg_prog_mem #(.STEPS(STEPS)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed_i    (armed),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (step_t'(wr_data_i)),
    .rd_idx_i   (ptr),
    .rd_step_o  (cur_step)
  );

  trg_event_sel #(.N_EDGE(N_EDGE), .N_BYTE(N_BYTE)) u_sel (
    .edge_i  (edge_i),
    .bvld_i  (bvld_i),
    .bdat_i  (bdat_i),
    .step_i  (cur_step),
    .hit_o   (hit),
    .miss_o  (miss),
    .abort_o (abort_ev)
  );

  trg_step_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm_i),
    .hit_i   (hit),
    .miss_i  (miss),
    .abort_i (abort_ev),
    .step_i  (cur_step),
    .armed_o (armed),
    .ptr_o   (ptr),
    .trig_o  (trig_o)
  );

  assign armed_o = armed;
  assign step_o  = ptr;

endmodule

// File: tb/trg_seq_bench.sv
module trg_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0;
  logic [3:0]  edge_i = '0;
  logic [1:0]  bvld_i = '0;
  logic [15:0] bdat_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o;
  logic [2:0]  wr_addr_i = '0;
  logic [21:0] wr_data_i = '0;
  logic        trig_o, armed_o;
  logic [2:0]  step_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trg_seq u_trg_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .edge_i(edge_i), .bvld_i(bvld_i),
    .bdat_i(bdat_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .trig_o(trig_o),
    .armed_o(armed_o), .step_o(step_o)
  );

  // ---------------- behavioural reference ----------------
  logic [21:0] prog [8];
  bit m_armed, m_trig;
  int m_ptr;

  function automatic logic [21:0] mk(int ev, int ce, int cv, int ab, int fr, int nh, int nm);
    return 22'((ev << 19) | (ce << 18) | (cv << 10) | (ab << 7) | (fr << 6) | (nh << 3) | nm);
  endfunction

  function automatic bit src_on(int sel);
    if (sel < 4) return edge_i[sel];
    if (sel < 6) return bvld_i[sel-4];
    return sel == 6;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (prog[i]) prog[i] = mk(7, 0, 0, 7, 0, 0, 0);
      m_armed = 0; m_trig = 0; m_ptr = 0;
    end else if (!m_armed) begin
      m_trig = 0;
      if (wr_valid_i) prog[wr_addr_i] = wr_data_i;
      if (arm_i) begin m_armed = 1; m_ptr = 0; end
    end else begin
      logic [21:0] p;
      int ev, ab, lane;
      bit fired, cmp, eq;
      p = prog[m_ptr];
      ev = int'(p[21:19]); ab = int'(p[9:7]);
      m_trig = 0;
      fired = src_on(ev);
      cmp = p[18] && (ev == 4 || ev == 5);
      lane = (ev == 5) ? 1 : 0;
      eq = (bdat_i[lane*8 +: 8] == p[17:10]);
      if (src_on(ab)) m_ptr = 0;
      else if (fired && (!cmp || eq)) begin
        if (p[6]) begin m_trig = 1; m_armed = 0; m_ptr = 0; end
        else m_ptr = int'(p[5:3]);
      end else if (fired) m_ptr = int'(p[2:0]);
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 trig_o vs model", int'(trig_o), int'(m_trig));
      chk("R6 step_o vs model", int'(step_o), m_ptr);
      chk("R4 armed_o vs model", int'(armed_o), int'(m_armed));
      chk("R2 wr_ready_o vs model", int'(wr_ready_o), int'(!m_armed));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(logic [3:0] e, logic [1:0] bv, logic [7:0] d0, logic [7:0] d1, logic a);
    edge_i = e; bvld_i = bv; bdat_i = {d1, d0}; arm_i = a;
    @(negedge clk);
    edge_i = '0; bvld_i = '0; arm_i = 1'b0;
  endtask

  task automatic wr(int addr, logic [21:0] data);
    wr_valid_i = 1'b1; wr_addr_i = 3'(addr); wr_data_i = data;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cycles, 150000);
      finish_run();
    end
  end

  localparam logic [3:0] RISE = 4'b0001;
  localparam logic [3:0] FALL = 4'b0010;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 trig_o after reset", int'(trig_o), 0);
    chk("R1 armed_o after reset", int'(armed_o), 0);
    chk("R1 step_o after reset", int'(step_o), 0);
    chk("R1 wr_ready_o after reset", int'(wr_ready_o), 1);
    // R1 inert program: arm and offer every event; nothing moves
    cyc(4'b0000, 2'b00, 8'h00, 8'h00, 1'b1);
    cyc(4'b1111, 2'b11, 8'h00, 8'h00, 1'b0);
    chk("R1 inert step holds", int'(step_o), 0);
    chk("R1 inert no trigger", int'(trig_o), 0);
    // need idle to load: reset again
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2 load serial-match program
    wr(0, mk(1, 0, 0, 7, 0, 1, 0));
    wr(1, mk(4, 1, 8'h41, 0, 0, 2, 0));
    wr(2, mk(4, 1, 8'h42, 0, 1, 0, 0));
    // R4 arm while an edge is present: ignored
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b1);
    chk("R4 armed after arm", int'(armed_o), 1);
    chk("R4 arming-cycle event ignored", int'(step_o), 0);
    chk("R2 ready low while armed", int'(wr_ready_o), 0);
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b0);
    chk("R6 advance on falling edge", int'(step_o), 1);
    cyc(0, 2'b01, 8'h41, 8'h00, 1'b0);
    chk("R7 equal byte advances", int'(step_o), 2);
    cyc(0, 2'b01, 8'h42, 8'h00, 1'b0);
    chk("R9 trigger pulse", int'(trig_o), 1);
    chk("R9 disarmed at trigger", int'(armed_o), 0);
    chk("R9 step 0 at trigger", int'(step_o), 0);
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b0);
    chk("R9 pulse one cycle", int'(trig_o), 0);
    chk("R9 no rearm without arm_i", int'(armed_o), 0);
    cyc(0, 2'b00, 8'h00, 8'h00, 1'b1);
    repeat (3) cyc(0, 2'b00, 8'h00, 8'h00, 1'b0);
    chk("R10 idle cycles hold step", int'(step_o), 0);
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b0);
    repeat (2) cyc(0, 2'b10, 8'h00, 8'h41, 1'b0);
    chk("R10 other lane strobe holds step", int'(step_o), 1);
    cyc(0, 2'b01, 8'h55, 8'h00, 1'b0);
    chk("R7 mismatched byte to miss successor", int'(step_o), 0);
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b0);
    cyc(RISE, 2'b00, 8'h00, 8'h00, 1'b0);
    chk("R8 abort returns to step 0", int'(step_o), 0);
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b0);
    cyc(0, 2'b01, 8'h41, 8'h00, 1'b0);
    cyc(RISE, 2'b01, 8'h42, 8'h00, 1'b0);
    chk("R8 abort beats final match step", int'(step_o), 0);
    chk("R8 abort beats final match trig", int'(trig_o), 0);
    chk("R8 still armed after abort", int'(armed_o), 1);
    // R3 write attempt while armed
    wr(2, mk(4, 1, 8'h99, 0, 1, 0, 0));
    cyc(FALL, 2'b00, 8'h00, 8'h00, 1'b0);
    cyc(0, 2'b01, 8'h41, 8'h00, 1'b0);
    cyc(0, 2'b01, 8'h42, 8'h00, 1'b0);
    chk("R3 armed write dropped, old byte fires", int'(trig_o), 1);

    // R5 second program: always source, edge 3, lane 1
    wr(0, mk(6, 0, 0, 7, 0, 1, 0));
    wr(1, mk(3, 1, 8'h00, 7, 0, 2, 0));
    wr(2, mk(5, 1, 8'h7E, 2, 1, 0, 2));
    cyc(0, 2'b00, 8'h00, 8'h00, 1'b1);
    chk("R5 armed at step 0", int'(step_o), 0);
    cyc(0, 2'b00, 8'h00, 8'h00, 1'b0);
    chk("R5 always source advances", int'(step_o), 1);
    cyc(4'b1000, 2'b01, 8'h33, 8'h00, 1'b0);
    chk("R7 compare ignored on edge select", int'(step_o), 2);
    cyc(0, 2'b01, 8'h7E, 8'h00, 1'b0);
    chk("R5 lane 0 not selected", int'(trig_o), 0);
    cyc(0, 2'b10, 8'h00, 8'h11, 1'b0);
    chk("R7 lane 1 miss to self", int'(step_o), 2);
    cyc(0, 2'b10, 8'h00, 8'h7E, 1'b0);
    chk("R5 lane 1 byte fires", int'(trig_o), 1);

    // randomized phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      arm_i = (r[2:0] == 0);
      edge_i = {r[8:5] & r[12:9] & r[16:13]};
      bvld_i = r[18:17] & r[20:19];
      bdat_i = {(r[21] ? 8'h42 : 8'(r[31:24])), (r[22] ? 8'h41 : 8'h42)};
      wr_valid_i = (r[23] && r[4:3] == 0);
      wr_addr_i = 3'($urandom);
      wr_data_i = 22'($urandom);
      @(negedge clk);
    end
    edge_i = '0; bvld_i = '0; arm_i = 1'b0; wr_valid_i = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule